// File: doc/BRIEF.md
# Camera Test Pattern Video Source

This block produces synthetic camera video so that a frame grabber can be exercised without a real sensor. On a single pixel clock it drives three nested framing strobes (frame valid, line valid, data valid) and a 64-bit pixel bus. Every pixel value is derived from where it sits in the frame, so a downstream checker can predict each word exactly.

A frame is armed by a one-cycle start pulse. At that pulse the block also samples the number of sensor outputs. One or two outputs give a single-tap stream, with one 16-bit pixel per beat. Four or eight outputs give a four-tap stream, with four pixels per beat. Any other count is refused and flagged.

Line width (in beats), frame height (in lines), horizontal blanking and vertical blanking are runtime inputs, latched when a frame begins. Two pattern modes exist. The area mode sends a running per-frame pixel count. The line mode sends the horizontal position, then an end-of-data marker word, then an identification tail whose values are offset from a base.

Top module: `cam_pat_src`

## Requirements
- R1: `lval` is high only while `fval` is high, and `dval` is high only while `lval` is high. `pix_data` is all zero in every cycle that is not a valid beat (all three strobes high). After reset all strobes, `pix_data`, `frame_done` and `cfg_err` are 0.
- R2: Single-tap streams (`sensor_outs` = 1 or 2) carry one pixel in bits [15:0], with bits [63:16] zero. The area count rises by 1 per valid beat.
- R3: Four-tap streams (`sensor_outs` = 4 or 8) carry the values v, v+1, v+2 and v+3 in bits [15:0], [31:16], [47:32] and [63:48]. Here v is the count in area mode or the horizontal position in line mode. v rises by 4 per valid beat.
- R4: In area mode (`scan_mode` = 0) v is a 14-bit count, zero-extended to 16 bits. It is 0 on the first beat of every frame. Once it exceeds 0x3FF0 it returns to 0 on the next clock.
- R5: `pos_x` gives the horizontal position of the current beat. It restarts at 0 on every line and advances with the beat step. `pos_y` gives the line number within the frame, starting at 0. It advances once after each falling edge of `lval`.
- R6: In line mode (`scan_mode` = 1), a lane at position p < `data_len` carries p.
- R7: In line mode, a lane whose p is not below `data_len` and equals `eod_index` or `eod_index`+1 carries the marker word (parameter, default 0xFFFF).
- R8: In line mode, any remaining lane with p >= `id_index` carries (p - `id_index`) + 0x0E00. All other lanes carry 0.
- R9: A start pulse with `sensor_outs` outside {1, 2, 4, 8} starts no frame and sets `cfg_err`. A start pulse with a legal value clears `cfg_err`.
- R10: A frame has `frame_height` lines of `line_width` beats each. The gap between lines is exactly max(`hblank`, 4) cycles with `fval` high. `fval` stays low for at least max(`vblank`, 8) cycles before each rise.
- R11: `frame_done` is high for exactly the one cycle in which `fval` is first low after a frame. A start pulse that arrives during a frame queues exactly one further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that arms a new frame |
| scan_mode | input | 1 | 0 area count pattern, 1 line pattern |
| sensor_outs | input | 4 | Number of sensor outputs (1, 2, 4, 8 legal) |
| line_width | input | 16 | Beats per line (0 treated as 1) |
| frame_height | input | 16 | Lines per frame (0 treated as 1) |
| hblank | input | 16 | Requested gap between lines |
| vblank | input | 16 | Requested blanking before and after a frame |
| data_len | input | 16 | Line mode: positions below this carry their position |
| eod_index | input | 16 | Line mode: first of two marker positions |
| id_index | input | 16 | Line mode: first position of the identification tail |
| fval | output | 1 | Frame valid |
| lval | output | 1 | Line valid |
| dval | output | 1 | Data valid |
| pix_data | output | 64 | Four 16-bit pixel lanes |
| pos_x | output | 16 | Horizontal position of the current beat |
| pos_y | output | 16 | Line number within the frame |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |
| cfg_err | output | 1 | Last start carried an illegal output count |

## Verification
The hardest condition to reach is the area-count wrap. It happens only after more than sixteen thousand single-tap beats within one frame, and it must land in the middle of a line, not inside a gap. The stimulus table therefore holds a 256-beat by 64-line single-tap frame, in which the count passes 0x3FF1 at beat 241 of a line. The bench captures the beat that follows it. A second hard case is a start pulse while a frame is running. The bench waits for `fval` to rise before pulsing start, then counts the frames that follow.

// File: rtl/cam_pat_pkg.sv
// Shared types and helpers for the camera test pattern source.
// Assumes sensor output counts are presented as a plain binary number.
package cam_pat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_LINE,
        ST_GAP,
        ST_POST
    } tstate_t;

    typedef enum logic {
        SCAN_AREA = 1'b0,
        SCAN_LINE = 1'b1
    } scan_t;

    // True when the sensor output count is one the block supports
    function automatic logic outs_legal(input logic [3:0] n);
        return (n == 4'd1) || (n == 4'd2) || (n == 4'd4) || (n == 4'd8);
    endfunction

    // True when the output count selects the four-tap stream
    function automatic logic outs_full(input logic [3:0] n);
        return (n == 4'd4) || (n == 4'd8);
    endfunction

endpackage

// File: rtl/cam_pat_timing.sv
// Frame timing generator: walks idle, pre-blank, line, gap and post-blank
// states and drives the three framing strobes from the state register.
// Assumes start is a single-cycle pulse; geometry is latched at frame load.
module cam_pat_timing
    import cam_pat_pkg::*;
#(
    parameter int DIM_W  = 16,
    parameter int MIN_HB = 4,
    parameter int MIN_VB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       sensor_outs,
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] height,
    input  logic [DIM_W-1:0] hblank,
    input  logic [DIM_W-1:0] vblank,
    output logic             fval,
    output logic             lval,
    output logic             dval,
    output logic             done,
    output logic             cfg_err,
    output logic             load
);

    localparam logic [DIM_W-1:0] HB_FLOOR = DIM_W'(MIN_HB);
    localparam logic [DIM_W-1:0] VB_FLOOR = DIM_W'(MIN_VB);
    localparam logic [DIM_W-1:0] ONE      = DIM_W'(1);

    tstate_t          st_q, st_n;
    logic [DIM_W-1:0] cnt_q, cnt_n;
    logic [DIM_W-1:0] line_q, line_n;
    logic [DIM_W-1:0] w_q, h_q, hb_q, vb_q;
    logic             arm_q;
    logic             legal;

    assign legal = outs_legal(sensor_outs);
    assign load  = (st_q == ST_IDLE) && arm_q;

    // Arm on a legal start, flag an illegal one, drop the arm on frame load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q   <= 1'b0;
            cfg_err <= 1'b0;
        end else if (start) begin
            arm_q   <= legal;
            cfg_err <= !legal;
        end else if (load) begin
            arm_q   <= 1'b0;
        end
    end

    // Latch frame geometry with the minimum blanking applied
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q  <= ONE;
            h_q  <= ONE;
            hb_q <= HB_FLOOR;
            vb_q <= VB_FLOOR;
        end else if (load) begin
            w_q  <= (width  == '0) ? ONE : width;
            h_q  <= (height == '0) ? ONE : height;
            hb_q <= (hblank < HB_FLOOR) ? HB_FLOOR : hblank;
            vb_q <= (vblank < VB_FLOOR) ? VB_FLOOR : vblank;
        end
    end

    // Next state, phase counter and line index
    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q + ONE;
        line_n = line_q;
        case (st_q)
            ST_IDLE: begin
                cnt_n  = '0;
                line_n = '0;
                if (arm_q) st_n = ST_PRE;
            end
            ST_PRE: begin
                if (cnt_q == vb_q - ONE) begin
                    st_n  = ST_LINE;
                    cnt_n = '0;
                end
            end
            ST_LINE: begin
                if (cnt_q == w_q - ONE) begin
                    cnt_n = '0;
                    if (line_q == h_q - ONE) begin
                        st_n   = ST_POST;
                        line_n = '0;
                    end else begin
                        st_n = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (cnt_q == hb_q - ONE) begin
                    st_n   = ST_LINE;
                    cnt_n  = '0;
                    line_n = line_q + ONE;
                end
            end
            ST_POST: begin
                if (cnt_q == vb_q - ONE) begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end
            end
            default: begin
                st_n  = ST_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    // State registers and the end-of-frame pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            line_q <= '0;
            done   <= 1'b0;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            line_q <= line_n;
            done   <= (st_q == ST_LINE) && (st_n == ST_POST);
        end
    end

    assign fval = (st_q == ST_LINE) || (st_q == ST_GAP);
    assign lval = (st_q == ST_LINE);
    assign dval = (st_q == ST_LINE);

endmodule

// File: rtl/cam_pat_coord.sv
// Coordinate tracker: follows the framing strobes and keeps the horizontal
// position, the line number and the per-frame area pixel count.
// Assumes the strobes come straight from registers of the timing generator.
module cam_pat_coord #(
    parameter int               POS_W    = 16,
    parameter int               CNT_W    = 14,
    parameter int               LANES    = 4,
    parameter logic [CNT_W-1:0] CNT_WRAP = 14'h3FF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fval,
    input  logic             lval,
    input  logic             dval,
    input  logic             full,
    output logic [POS_W-1:0] pos_x,
    output logic [POS_W-1:0] pos_y,
    output logic [CNT_W-1:0] count
);

    logic beat;
    logic lval_d;

    assign beat = fval && lval && dval;

    // Horizontal position: cleared outside a line, advanced per beat
    always_ff @(posedge clk) begin
        if (!rst_n || !fval || !lval) begin
            pos_x <= '0;
        end else if (beat) begin
            pos_x <= pos_x + (full ? POS_W'(LANES) : POS_W'(1));
        end
    end

    // Line number: cleared outside a frame, advanced after each line ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lval_d <= 1'b0;
            pos_y  <= '0;
        end else begin
            lval_d <= lval;
            if (!fval) pos_y <= '0;
            else if (lval_d && !lval) pos_y <= pos_y + POS_W'(1);
        end
    end

    // Area pixel count: cleared outside a frame, wraps once past the limit
    always_ff @(posedge clk) begin
        if (!rst_n || !fval || (count > CNT_WRAP)) begin
            count <= '0;
        end else if (beat) begin
            count <= count + (full ? CNT_W'(LANES) : CNT_W'(1));
        end
    end

endmodule

// File: rtl/cam_pat_pixel.sv
// Lane generator: forms each pixel lane from the area count or from the
// line position, and zeroes every lane outside a valid beat.
// Assumes lane 0 alone is live in the single-tap stream.
module cam_pat_pixel
    import cam_pat_pkg::*;
#(
    parameter int               LANES    = 4,
    parameter int               PIX_W    = 16,
    parameter int               CNT_W    = 14,
    parameter logic [PIX_W-1:0] EOD_WORD = 16'hFFFF,
    parameter logic [PIX_W-1:0] ID_BASE  = 16'h0E00
) (
    input  scan_t                  mode,
    input  logic                   full,
    input  logic                   valid,
    input  logic [PIX_W-1:0]       pos_x,
    input  logic [CNT_W-1:0]       count,
    input  logic [PIX_W-1:0]       data_len,
    input  logic [PIX_W-1:0]       eod_index,
    input  logic [PIX_W-1:0]       id_index,
    output logic [LANES*PIX_W-1:0] pix_data
);

    localparam int EW = PIX_W + 1;

    logic [EW-1:0] len_e, eod_e, eod_n, id_e;

    assign len_e = {1'b0, data_len};
    assign eod_e = {1'b0, eod_index};
    assign eod_n = {1'b0, eod_index} + EW'(1);
    assign id_e  = {1'b0, id_index};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [EW-1:0]    p;
        logic [PIX_W-1:0] area_v;
        logic [PIX_W-1:0] line_v;
        logic             live;

        assign p      = {1'b0, pos_x} + EW'(k);
        assign area_v = PIX_W'(count) + PIX_W'(k);
        assign live   = valid && (full || (k == 0));

        // Line pattern priority: data, then marker pair, then tail
        always_comb begin
            if (p < len_e)                     line_v = p[PIX_W-1:0];
            else if ((p == eod_e) || (p == eod_n)) line_v = EOD_WORD;
            else if (p >= id_e)                line_v = PIX_W'(p - id_e) + ID_BASE;
            else                               line_v = '0;
        end

        assign pix_data[k*PIX_W +: PIX_W] =
            !live ? '0 : ((mode == SCAN_LINE) ? line_v : area_v);
    end

endmodule

// File: rtl/cam_pat_src.sv
// Camera test pattern source top: ties the timing generator, coordinate
// tracker and lane generator together and latches the pattern settings
// when a frame is loaded. Assumes inputs are synchronous to clk.
module cam_pat_src
    import cam_pat_pkg::*;
#(
    parameter int               DIM_W    = 16,
    parameter int               PIX_W    = 16,
    parameter int               LANES    = 4,
    parameter int               CNT_W    = 14,
    parameter logic [CNT_W-1:0] CNT_WRAP = 14'h3FF0,
    parameter logic [PIX_W-1:0] EOD_WORD = 16'hFFFF,
    parameter logic [PIX_W-1:0] ID_BASE  = 16'h0E00,
    parameter int               MIN_HB   = 4,
    parameter int               MIN_VB   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   scan_mode,
    input  logic [3:0]             sensor_outs,
    input  logic [DIM_W-1:0]       line_width,
    input  logic [DIM_W-1:0]       frame_height,
    input  logic [DIM_W-1:0]       hblank,
    input  logic [DIM_W-1:0]       vblank,
    input  logic [PIX_W-1:0]       data_len,
    input  logic [PIX_W-1:0]       eod_index,
    input  logic [PIX_W-1:0]       id_index,
    output logic                   fval,
    output logic                   lval,
    output logic                   dval,
    output logic [LANES*PIX_W-1:0] pix_data,
    output logic [PIX_W-1:0]       pos_x,
    output logic [PIX_W-1:0]       pos_y,
    output logic                   frame_done,
    output logic                   cfg_err
);

    logic             load;
    scan_t            mode_q;
    logic             full_q;
    logic [PIX_W-1:0] len_q, eod_q, id_q;
    logic [CNT_W-1:0] count;

    cam_pat_timing #(
        .DIM_W  (DIM_W),
        .MIN_HB (MIN_HB),
        .MIN_VB (MIN_VB)
    ) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .sensor_outs (sensor_outs),
        .width       (line_width),
        .height      (frame_height),
        .hblank      (hblank),
        .vblank      (vblank),
        .fval        (fval),
        .lval        (lval),
        .dval        (dval),
        .done        (frame_done),
        .cfg_err     (cfg_err),
        .load        (load)
    );

    // Pattern settings held constant for the whole frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SCAN_AREA;
            full_q <= 1'b0;
            len_q  <= '0;
            eod_q  <= '0;
            id_q   <= '0;
        end else if (load) begin
            mode_q <= scan_t'(scan_mode);
            full_q <= outs_full(sensor_outs);
            len_q  <= data_len;
            eod_q  <= eod_index;
            id_q   <= id_index;
        end
    end

    cam_pat_coord #(
        .POS_W    (PIX_W),
        .CNT_W    (CNT_W),
        .LANES    (LANES),
        .CNT_WRAP (CNT_WRAP)
    ) u_coord (
        .clk   (clk),
        .rst_n (rst_n),
        .fval  (fval),
        .lval  (lval),
        .dval  (dval),
        .full  (full_q),
        .pos_x (pos_x),
        .pos_y (pos_y),
        .count (count)
    );

    cam_pat_pixel #(
        .LANES    (LANES),
        .PIX_W    (PIX_W),
        .CNT_W    (CNT_W),
        .EOD_WORD (EOD_WORD),
        .ID_BASE  (ID_BASE)
    ) u_pixel (
        .mode      (mode_q),
        .full      (full_q),
        .valid     (fval && lval && dval),
        .pos_x     (pos_x),
        .count     (count),
        .data_len  (len_q),
        .eod_index (eod_q),
        .id_index  (id_q),
        .pix_data  (pix_data)
    );

endmodule

// File: rtl/cam_pat_src_chk.sv
// Property checker for the camera test pattern source, attached by bind.
// Watches only the top-level ports; blanking windows use local counters.
module cam_pat_src_chk #(
    parameter int DATA_W = 64,
    parameter int MIN_HB = 4,
    parameter int MIN_VB = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fval,
    input logic              lval,
    input logic              dval,
    input logic [DATA_W-1:0] pix_data,
    input logic              frame_done
);

    logic [7:0] gap_cnt;
    logic [7:0] low_cnt;

    // Count gap cycles inside a frame and idle cycles outside one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            low_cnt <= '0;
        end else begin
            if (lval || !fval)        gap_cnt <= '0;
            else if (gap_cnt != 8'hFF) gap_cnt <= gap_cnt + 8'd1;
            if (fval)                 low_cnt <= '0;
            else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 8'd1;
        end
    end

    p_line_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lval |-> fval);

    p_data_in_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dval |-> lval);

    p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(fval && lval && dval) |-> (pix_data == '0));

    p_done_at_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $fell(fval));

    p_fall_flags_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fval) |-> frame_done);

    p_hgap_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lval) && $past(fval)) |-> (gap_cnt >= 8'(MIN_HB)));

    p_vgap_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fval) |-> (low_cnt >= 8'(MIN_VB)));

endmodule

bind cam_pat_src cam_pat_src_chk #(
    .DATA_W (LANES*PIX_W),
    .MIN_HB (MIN_HB),
    .MIN_VB (MIN_VB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fval       (fval),
    .lval       (lval),
    .dval       (dval),
    .pix_data   (pix_data),
    .frame_done (frame_done)
);

// File: tb/cam_pat_src_bench.sv
`timescale 1ns/1ps
module cam_pat_src_bench;

    typedef struct packed {
        logic        mode;
        logic [3:0]  outs;
        logic [15:0] w, h, hb, vb, dl, eo, id;
    } vec_t;

    // mode, outs, width, height, hblank, vblank, data_len, eod, id
    localparam vec_t VEC [0:5] = '{
        '{1'b0, 4'd1, 16'd6,   16'd3,  16'd5, 16'd10, 16'd0, 16'd0,  16'd0},
        '{1'b0, 4'd4, 16'd5,   16'd4,  16'd0, 16'd0,  16'd0, 16'd0,  16'd0},
        '{1'b1, 4'd2, 16'd20,  16'd2,  16'd4, 16'd8,  16'd8, 16'd10, 16'd14},
        '{1'b1, 4'd8, 16'd6,   16'd2,  16'd6, 16'd9,  16'd5, 16'd6,  16'd12},
        '{1'b0, 4'd2, 16'd256, 16'd64, 16'd4, 16'd8,  16'd0, 16'd0,  16'd0},
        '{1'b1, 4'd1, 16'd12,  16'd2,  16'd4, 16'd8,  16'd8, 16'd4,  16'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        scan_mode = 1'b0;
    logic [3:0]  sensor_outs = 4'd1;
    logic [15:0] line_width = 16'd1, frame_height = 16'd1, hblank = '0, vblank = '0;
    logic [15:0] data_len = '0, eod_index = '0, id_index = '0;
    logic        fval, lval, dval, frame_done, cfg_err;
    logic [63:0] pix_data;
    logic [15:0] pos_x, pos_y;

    always #10 clk = ~clk;

    cam_pat_src u_cam_pat_src (
        .clk(clk), .rst_n(rst_n), .start(start), .scan_mode(scan_mode),
        .sensor_outs(sensor_outs), .line_width(line_width),
        .frame_height(frame_height), .hblank(hblank), .vblank(vblank),
        .data_len(data_len), .eod_index(eod_index), .id_index(id_index),
        .fval(fval), .lval(lval), .dval(dval), .pix_data(pix_data),
        .pos_x(pos_x), .pos_y(pos_y), .frame_done(frame_done), .cfg_err(cfg_err)
    );

    int   n_chk = 0, n_fail = 0;
    int   frames = 0, rises = 0;
    vec_t cur;
    logic finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] line_val(input vec_t c, input logic [16:0] p);
        if (p < {1'b0, c.dl})                                   return p[15:0];
        if (p == {1'b0, c.eo} || p == {1'b0, c.eo} + 17'd1)     return 16'hFFFF;
        if (p >= {1'b0, c.id})                                  return 16'(p - {1'b0, c.id}) + 16'h0E00;
        return 16'h0000;
    endfunction

    function automatic logic [63:0] exp_data(input vec_t c, input logic [15:0] x, input logic [13:0] cnt);
        logic [63:0] r = '0;
        bit f = (c.outs == 4'd4) || (c.outs == 4'd8);
        for (int k = 0; k < 4; k++) begin
            if (k == 0 || f)
                r[k*16 +: 16] = c.mode ? line_val(c, {1'b0, x} + 17'(k)) : (16'(cnt) + 16'(k));
        end
        return r;
    endfunction

    // Bench-side model state
    logic [15:0] bx, by;
    logic [13:0] bcnt;
    logic        pf, pl;
    int          len, lines, gap, low;
    logic [15:0] last_l0, wrap_val;
    bit          wrap_seen = 0;

    // Monitor: samples outputs on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            bx = '0; by = '0; bcnt = '0; pf = 0; pl = 0;
            len = 0; lines = 0; gap = 0; low = 0; last_l0 = '0;
        end else if (!finished) begin
            bit v, f;
            int hbx, vbx;
            logic [63:0] e;
            v   = fval && lval && dval;
            f   = (cur.outs == 4'd4) || (cur.outs == 4'd8);
            hbx = (cur.hb < 4) ? 4 : int'(cur.hb);
            vbx = (cur.vb < 8) ? 8 : int'(cur.vb);
            if (v) begin
                e = exp_data(cur, bx, bcnt);
                if (cur.mode) chk(pix_data == e, "R6 R7 R8 line pattern", pix_data, e);
                else if (f)   chk(pix_data == e, "R3 R4 four-tap count", pix_data, e);
                else          chk(pix_data == e, "R2 R4 single-tap count", pix_data, e);
                chk(pos_x == bx && pos_y == by, "R5 position", {pos_x, pos_y}, {bx, by});
                if (!cur.mode && !f) begin
                    if (last_l0 == 16'h3FF1) begin
                        wrap_val = pix_data[15:0];
                        wrap_seen = 1;
                    end
                    last_l0 = pix_data[15:0];
                end
                len++;
            end else begin
                chk(pix_data == '0, "R1 idle bus", pix_data, 64'd0);
            end
            chk(!(lval && !fval) && !(dval && !lval), "R1 nesting", {fval, lval, dval}, 3'b111);
            if (pl && !lval) begin
                chk(len == int'(cur.w), "R10 line width", 64'(len), 64'(cur.w));
                lines++; len = 0; gap = 0;
            end
            if (fval && !lval && pf) gap++;
            if (lval && !pl && pf)
                chk(gap == hbx, "R10 line gap", 64'(gap), 64'(hbx));
            if (fval && !pf) begin
                chk(low >= vbx, "R10 vertical blank", 64'(low), 64'(vbx));
                low = 0; lines = 0; rises++; last_l0 = '0;
            end
            if (!fval) low++;
            if (!fval && pf) begin
                chk(lines == int'(cur.h), "R10 frame height", 64'(lines), 64'(cur.h));
                chk(frame_done, "R11 done at fall", 64'(frame_done), 64'd1);
                frames++;
            end else if (frame_done) begin
                chk(0, "R11 stray done", 64'd1, 64'd0);
            end
            by   = !fval ? 16'd0 : ((pl && !lval) ? by + 16'd1 : by);
            bx   = (!fval || !lval) ? 16'd0 : (v ? bx + (f ? 16'd4 : 16'd1) : bx);
            bcnt = !fval ? 14'd0 : ((bcnt > 14'h3FF0) ? 14'd0 : (v ? bcnt + (f ? 14'd4 : 14'd1) : bcnt));
            pf = fval; pl = lval;
        end
    end

    task automatic apply(input vec_t c);
        @(posedge clk); #2;
        cur = c;
        scan_mode = c.mode; sensor_outs = c.outs;
        line_width = c.w; frame_height = c.h; hblank = c.hb; vblank = c.vb;
        data_len = c.dl; eod_index = c.eo; id_index = c.id;
    endtask

    task automatic pulse_start();
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
    endtask

    task automatic wait_frames(input int target);
        int t = 0;
        while (frames < target && t < 40000) begin
            @(negedge clk);
            t++;
        end
        if (frames < target) chk(0, "R11 watchdog frame wait", 64'(frames), 64'(target));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        cur = VEC[0];
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({fval, lval, dval, frame_done, cfg_err} == 5'b0 && pix_data == '0,
            "R1 reset state", {fval, lval, dval, frame_done, cfg_err}, 64'd0);
        @(posedge clk); #2 rst_n = 1'b1;
        idle(4);

        // Table walk: one frame per vector
        for (int i = 0; i < 6; i++) begin
            int want;
            want = frames + 1;
            apply(VEC[i]);
            pulse_start();
            wait_frames(want);
            idle(30);
        end
        chk(wrap_seen && wrap_val == 16'd0, "R4 count wrap", {wrap_seen, wrap_val}, 64'd0);

        // Illegal output counts refused
        begin
            int r0;
            r0 = rises;
            apply('{1'b0, 4'd3, 16'd4, 16'd2, 16'd4, 16'd8, 16'd0, 16'd0, 16'd0});
            pulse_start();
            idle(40);
            chk(cfg_err == 1'b1, "R9 error on 3 outputs", 64'(cfg_err), 64'd1);
            chk(rises == r0, "R9 no frame on 3 outputs", 64'(rises), 64'(r0));
            apply('{1'b0, 4'd6, 16'd4, 16'd2, 16'd4, 16'd8, 16'd0, 16'd0, 16'd0});
            pulse_start();
            idle(40);
            chk(cfg_err == 1'b1 && rises == r0, "R9 no frame on 6 outputs", {cfg_err, 32'(rises)}, {1'b1, 32'(r0)});
        end

        // Legal start clears the error; a start mid-frame queues one frame
        begin
            int f0, r0, t;
            f0 = frames;
            apply(VEC[0]);
            pulse_start();
            idle(1);
            chk(cfg_err == 1'b0, "R9 legal start clears error", 64'(cfg_err), 64'd0);
            t = 0;
            while (!fval && t < 200) begin @(negedge clk); t++; end
            pulse_start();
            wait_frames(f0 + 2);
            r0 = rises;
            idle(80);
            chk(rises == r0 && frames == f0 + 2, "R11 exactly one queued frame", 64'(frames), 64'(f0 + 2));
        end

        // Reset in the middle of a frame
        begin
            int t;
            apply(VEC[1]);
            pulse_start();
            t = 0;
            while (!lval && t < 200) begin @(negedge clk); t++; end
            @(posedge clk); #2 rst_n = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk({fval, lval, dval, frame_done, cfg_err} == 5'b0 && pix_data == '0,
                "R1 reset mid-frame", {fval, lval, dval, frame_done, cfg_err}, 64'd0);
            @(posedge clk); #2 rst_n = 1'b1;
            idle(4);
        end

        finish_run();
    end

    // Watchdog: a hung run ends as a failed check
    initial begin
        #(190000 * 20);
        chk(0, "R11 watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

endmodule